// File: doc/BRIEF.md
# Serial Peripheral Byte DMA Channel Pair

This block moves bytes between one serial peripheral and system memory without processor help. It holds two channels. The receive channel stores each byte the peripheral has received. The transmit channel fetches each byte the peripheral is ready to send. Each channel keeps a 32-bit memory pointer and a 16-bit remaining-byte counter. Both values can be written and read over a small word-addressed register port. That port is meant to sit inside the owning peripheral's register window.

A channel is armed by writing a nonzero count. Each completed byte moves the pointer up by one and lowers the count by one. When the count reaches zero the channel goes quiet. Its end-of-transfer output then stays high, and the peripheral forwards it as its own interrupt. The two channels share one memory master port. That port uses a request/grant handshake followed by an acknowledge pulse, and it carries one transaction at a time. When both channels want the port, receive wins so that incoming bytes are not lost.

Top module: `periph_dma_pair`

## Requirements
- R1: After reset, both pointers and both counts read as zero, `rx_eot` and `tx_eot` are high, and `mem_req` is low.
- R2: Register word address 0 holds the receive pointer, 1 the receive count, 2 the transmit pointer and 3 the transmit count. A write stores the word, except that a count keeps only `reg_wdata[15:0]`. A read returns the stored value, with counts zero-extended to 32 bits.
- R3: A channel whose count is zero issues no memory request, whatever its peripheral signals. The pending peripheral byte is left untouched.
- R4: While `rx_valid` is high and the receive count is nonzero, the block issues a write (`mem_we`=1) of `rx_byte` to the receive pointer address. `rx_taken` pulses in the cycle of the acknowledge.
- R5: While `tx_ready` is high and the transmit count is nonzero, the block issues a read (`mem_we`=0) at the transmit pointer address. `tx_load` pulses in the acknowledge cycle, and `tx_byte` then carries `mem_rdata`.
- R6: Each acknowledged transfer raises the owning channel's pointer by one and lowers its count by one.
- R7: `mem_req` stays high until a cycle with `mem_gnt` high and drops in the next cycle. No new request appears until `mem_ack` has completed the granted one.
- R8: When both channels are eligible in the same idle cycle, the receive channel is served first.
- R9: A channel's end-of-transfer output is high exactly while its count is zero. It falls on a nonzero count write and rises after the final byte is acknowledged.
- R10: The pointer is a 32-bit wrapping value: a transfer at address 0xFFFFFFFF leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| rx_valid | input | 1 | Peripheral holds a received byte |
| rx_byte | input | 8 | Received byte |
| rx_taken | output | 1 | Received byte stored in memory |
| tx_ready | input | 1 | Peripheral can accept a byte |
| tx_byte | output | 8 | Byte fetched for the peripheral |
| tx_load | output | 1 | `tx_byte` is valid this cycle |
| rx_eot | output | 1 | Receive end of transfer |
| tx_eot | output | 1 | Transmit end of transfer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_ack | input | 1 | Transaction complete |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |

## Verification
A corrupted pointer appears in `mem_addr` on the next request. A corrupted count appears as one byte too many or too few, and the bench sees that through the register readback and the end-of-transfer output as soon as the run stops. A sequencer stuck in the wrong phase shows up within a cycle as a request that is dropped before grant or reissued before acknowledge. A wrong priority shows up in the order of the memory transactions logged at the port. A count check that is skipped shows up as a request or a consumed peripheral byte while the count reads zero.

// File: rtl/pdma_pkg.sv
// Shared constants and types for the peripheral DMA channel pair.
// Assumes exactly two channels: index 0 serves receive, index 1 serves transmit.
package pdma_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_RX  = 0;   // lower index wins arbitration
    localparam int CH_TX  = 1;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int REG_AW = CH_W + 1;  // {channel, is_count}

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pdma_channel.sv
// One DMA channel: pointer and count registers plus eligibility.
// Assumes PTR_W >= CNT_W. A register write has priority over a completion
// in the same cycle. A zero count never becomes eligible.
module pdma_channel #(
    parameter int PTR_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_wr,
    input  logic             cnt_wr,
    input  logic [PTR_W-1:0] wdata,
    input  logic             periph_rdy,
    input  logic             xfer_done,
    output logic [PTR_W-1:0] ptr_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             want,
    output logic             eot
);
    logic armed;

    // Pointer: load from the register port, else step after each byte.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr_q <= '0;
        else if (ptr_wr)    ptr_q <= wdata;
        else if (xfer_done) ptr_q <= ptr_q + 1'b1;
    end

    // Count: load from the register port, else step down after each byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (cnt_wr)             cnt_q <= wdata[CNT_W-1:0];
        else if (xfer_done && armed) cnt_q <= cnt_q - 1'b1;
    end

    // Eligibility and end-of-transfer follow directly from the count.
    always_comb begin
        armed = (cnt_q != '0);
        want  = armed && periph_rdy;
        eot   = !armed;
    end
endmodule

// File: rtl/pdma_regs.sv
// Register decode for the channel pair. Word address = {channel, is_count}.
// Reads are combinational. Counts are zero-extended.
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int PTR_W = 32,
    parameter int CNT_W = 16
) (
    input  logic                          reg_wr,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [NUM_CH-1:0][PTR_W-1:0]  ptr_q,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_q,
    output logic [NUM_CH-1:0]             ptr_wr,
    output logic [NUM_CH-1:0]             cnt_wr,
    output logic [PTR_W-1:0]              reg_rdata
);
    logic [CH_W-1:0] sel;

    // Per-channel write strobes.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
        assign ptr_wr[ch] = reg_wr && (reg_addr[REG_AW-1:1] == CH_W'(ch)) && !reg_addr[0];
        assign cnt_wr[ch] = reg_wr && (reg_addr[REG_AW-1:1] == CH_W'(ch)) &&  reg_addr[0];
    end

    // Read multiplexer.
    always_comb begin
        sel       = reg_addr[REG_AW-1:1];
        reg_rdata = reg_addr[0] ? {{(PTR_W-CNT_W){1'b0}}, cnt_q[sel]} : ptr_q[sel];
    end
endmodule

// File: rtl/pdma_seq.sv
// Shared memory-port sequencer. In idle it picks the lowest-index eligible
// channel and latches its address, direction and data. It holds the request
// until grant, then waits for the acknowledge. One transaction at a time.
module pdma_seq
    import pdma_pkg::*;
#(
    parameter int PTR_W  = 32,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0]             want,
    input  logic [NUM_CH-1:0][PTR_W-1:0]  ptr_q,
    input  logic [DATA_W-1:0]             rx_data,
    input  logic                          mem_gnt,
    input  logic                          mem_ack,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [PTR_W-1:0]              mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    output logic [NUM_CH-1:0]             done
);
    seq_state_t      state;
    logic [CH_W-1:0] owner, pick;
    logic            any;

    // Fixed priority: the lowest index (receive) wins.
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (want[i]) begin
                pick = CH_W'(i);
                any  = 1'b1;
            end
        end
    end

    // Transaction phase and latched transaction fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            owner     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (any) begin
                    owner     <= pick;
                    mem_we    <= (pick == CH_W'(CH_RX));
                    mem_addr  <= ptr_q[pick];
                    mem_wdata <= rx_data;
                    state     <= SEQ_REQ;
                end
                SEQ_REQ:  if (mem_gnt) state <= SEQ_WAIT;
                SEQ_WAIT: if (mem_ack) state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    // Request level and per-channel completion pulses.
    always_comb begin
        mem_req = (state == SEQ_REQ);
        for (int i = 0; i < NUM_CH; i++) begin
            done[i] = (state == SEQ_WAIT) && mem_ack && (owner == CH_W'(i));
        end
    end
endmodule

// File: rtl/periph_dma_pair.sv
// Top: receive and transmit DMA channels for one serial peripheral.
// The register port sits in the peripheral's own window. The end-of-transfer
// outputs feed the peripheral's interrupt logic. The peripheral is expected
// to drop rx_valid after rx_taken and to take tx_byte when tx_load is high.
module periph_dma_pair
    import pdma_pkg::*;
#(
    parameter int PTR_W  = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [PTR_W-1:0]  reg_wdata,
    output logic [PTR_W-1:0]  reg_rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              rx_taken,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_load,
    output logic              rx_eot,
    output logic              tx_eot,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [NUM_CH-1:0][PTR_W-1:0] ptr_q;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_CH-1:0]            ptr_wr, cnt_wr, want, eot, done, periph_rdy;

    // Peripheral readiness per channel, by channel index.
    always_comb begin
        periph_rdy        = '0;
        periph_rdy[CH_RX] = rx_valid;
        periph_rdy[CH_TX] = tx_ready;
    end

    pdma_regs #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_regs (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .ptr_q     (ptr_q),
        .cnt_q     (cnt_q),
        .ptr_wr    (ptr_wr),
        .cnt_wr    (cnt_wr),
        .reg_rdata (reg_rdata)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pdma_channel #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .ptr_wr     (ptr_wr[ch]),
            .cnt_wr     (cnt_wr[ch]),
            .wdata      (reg_wdata),
            .periph_rdy (periph_rdy[ch]),
            .xfer_done  (done[ch]),
            .ptr_q      (ptr_q[ch]),
            .cnt_q      (cnt_q[ch]),
            .want       (want[ch]),
            .eot        (eot[ch])
        );
    end

    pdma_seq #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want),
        .ptr_q     (ptr_q),
        .rx_data   (rx_byte),
        .mem_gnt   (mem_gnt),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done)
    );

    // Peripheral-side outputs.
    always_comb begin
        rx_taken = done[CH_RX];
        tx_load  = done[CH_TX];
        tx_byte  = mem_rdata;
        rx_eot   = eot[CH_RX];
        tx_eot   = eot[CH_TX];
    end
endmodule

// File: rtl/pdma_checker.sv
// Protocol and counting checks for periph_dma_pair, attached with bind.
module pdma_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic             mem_ack,
    input logic             mem_we,
    input logic             rx_valid,
    input logic             rx_taken,
    input logic             rx_eot,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [CNT_W-1:0] tx_cnt
);
    logic pend;

    // Tracks a granted transaction that has not been acknowledged yet.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend <= 1'b0;
        else if (mem_req && mem_gnt) pend <= 1'b1;
        else if (mem_ack)          pend <= 1'b0;
    end

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req);

    assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !mem_req);

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_taken && !(reg_wr && reg_addr == 2'd1) |=> rx_cnt == CNT_W'($past(rx_cnt) - 1'b1));

    assert_rx_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && mem_we |-> $past(rx_cnt) != '0);

    assert_tx_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && !mem_we |-> $past(tx_cnt) != '0);

    assert_rx_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && !mem_we |-> !($past(rx_valid) && $past(rx_cnt) != '0));

    assert_eot_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_eot) |-> $past(rx_taken) || $past(reg_wr));
endmodule

bind periph_dma_pair pdma_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .mem_req  (mem_req),
    .mem_gnt  (mem_gnt),
    .mem_ack  (mem_ack),
    .mem_we   (mem_we),
    .rx_valid (rx_valid),
    .rx_taken (rx_taken),
    .rx_eot   (rx_eot),
    .rx_cnt   (cnt_q[0]),
    .tx_cnt   (cnt_q[1])
);

// File: tb/periph_dma_pair_tb.sv
// Directed bench: memory responder and peripheral models in one negedge loop.
// Each scenario task drives and checks its own results.
module periph_dma_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_taken;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_load;
    logic        rx_eot, tx_eot;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int checks = 0, errors = 0;

    // Memory and peripheral models.
    logic [7:0]  mem [256];
    logic [7:0]  rx_q [64];
    int          rx_n = 0, rx_i = 0;
    bit          rx_pop = 0, tx_en = 0;
    logic [7:0]  tx_got [64];
    int          tx_n = 0;
    logic [31:0] log_addr [64];
    logic        log_we [64];
    int          log_n = 0;
    int          phase = 0, stall_cfg = 0, stall_left = 0, ack_delay = 0, wait_left = 0;
    int          viol = 0, held = 0;
    bit          req_seen = 0;
    logic [31:0] cap_addr;
    logic        cap_we;
    logic [7:0]  cap_wd;

    periph_dma_pair u_dut (.*);

    always #10 clk = ~clk;

    // Memory responder and peripheral models, stepping on each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rx_pop) begin rx_i++; rx_pop = 0; end
            rx_valid = (rx_i < rx_n);
            rx_byte  = (rx_i < rx_n) ? rx_q[rx_i] : 8'h00;
            tx_ready = tx_en;
            case (phase)
                0: begin
                    if (req_seen && !mem_req) viol++;
                    if (mem_req) begin
                        if (stall_left > 0) begin
                            stall_left--; held++; req_seen = 1;
                        end else begin
                            mem_gnt = 1'b1; req_seen = 0;
                            cap_addr = mem_addr; cap_we = mem_we; cap_wd = mem_wdata;
                            phase = 1;
                        end
                    end
                end
                1: begin
                    mem_gnt = 1'b0;
                    if (mem_req) viol++;
                    wait_left = ack_delay;
                    phase = 2;
                end
                default: begin
                    if (mem_req) viol++;
                    if (wait_left > 0) wait_left--;
                    else begin
                        mem_ack   = 1'b1;
                        mem_rdata = mem[cap_addr[7:0]];
                        if (cap_we) begin mem[cap_addr[7:0]] = cap_wd; rx_pop = 1; end
                        if (log_n < 64) begin
                            log_addr[log_n] = cap_addr; log_we[log_n] = cap_we; log_n++;
                        end
                        #1;
                        if (tx_load && tx_n < 64) begin tx_got[tx_n] = tx_byte; tx_n++; end
                        phase = 0;
                        stall_left = stall_cfg;
                    end
                end
            endcase
        end
    end

    task automatic tick();
        @(negedge clk); #3;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_eot(bit tx);
        for (int i = 0; i < 400; i++) begin
            if (tx ? tx_eot : rx_eot) break;
            tick();
        end
        tick(); tick();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d); chk("R1 register zero after reset", d, 0);
        end
        chk("R1 rx_eot", {31'b0, rx_eot}, 1);
        chk("R1 tx_eot", {31'b0, tx_eot}, 1);
        chk("R1 mem_req", {31'b0, mem_req}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(2'd0, 32'hCAFE_0001); wr(2'd2, 32'h1234_5678);
        rd(2'd0, d); chk("R2 rx pointer", d, 32'hCAFE_0001);
        rd(2'd2, d); chk("R2 tx pointer", d, 32'h1234_5678);
        wr(2'd1, 32'hABCD_0005); rd(2'd1, d); chk("R2 rx count low half", d, 32'h0000_0005);
        wr(2'd1, 32'h0); rd(2'd1, d); chk("R2 rx count cleared", d, 0);
        chk("R2 no request with idle peripheral", {31'b0, mem_req}, 0);
    endtask

    task automatic t_zero();
        rx_q[0] = 8'h99; rx_n = 1; rx_i = 0; tx_en = 1;
        for (int i = 0; i < 20; i++) tick();
        chk("R3 no transaction while counts zero", log_n, 0);
        chk("R3 rx byte left pending", rx_i, 0);
        chk("R3 no tx_load", tx_n, 0);
        tx_en = 0; rx_n = 0; rx_i = 0;
        tick(); tick();
    endtask

    task automatic t_rx();
        logic [31:0] d;
        int base = log_n;
        stall_cfg = 1; stall_left = 1; ack_delay = 2;
        rx_q[0] = 8'h11; rx_q[1] = 8'h22; rx_q[2] = 8'h33; rx_q[3] = 8'h44;
        rx_n = 4; rx_i = 0;
        wr(2'd0, 32'h40); wr(2'd1, 32'd3);
        chk("R9 rx_eot low once armed", {31'b0, rx_eot}, 0);
        wait_eot(0);
        chk("R4 byte 0 stored", mem[8'h40], 8'h11);
        chk("R4 byte 1 stored", mem[8'h41], 8'h22);
        chk("R4 byte 2 stored", mem[8'h42], 8'h33);
        chk("R4 write direction", {31'b0, log_we[base]}, 1);
        chk("R4 first address", log_addr[base], 32'h40);
        chk("R4 three transactions", log_n - base, 3);
        rd(2'd0, d); chk("R6 rx pointer advanced", d, 32'h43);
        rd(2'd1, d); chk("R6 rx count exhausted", d, 0);
        chk("R9 rx_eot high at end", {31'b0, rx_eot}, 1);
        chk("R3 fourth byte not taken", rx_i, 3);
        rx_n = 0; rx_i = 0;
        tick(); tick();
    endtask

    task automatic t_tx();
        logic [31:0] d;
        int base = log_n;
        stall_cfg = 3; stall_left = 3; ack_delay = 0; tx_n = 0;
        for (int i = 0; i < 4; i++) mem[8'h80 + i] = 8'hA0 + 8'(i);
        wr(2'd2, 32'h80); wr(2'd3, 32'd4);
        tx_en = 1;
        wait_eot(1);
        tx_en = 0;
        chk("R5 four bytes loaded", tx_n, 4);
        for (int i = 0; i < 4; i++) chk("R5 tx byte value", tx_got[i], 32'hA0 + i);
        chk("R5 read direction", {31'b0, log_we[base]}, 0);
        chk("R5 last address", log_addr[base + 3], 32'h83);
        rd(2'd2, d); chk("R6 tx pointer advanced", d, 32'h84);
        chk("R9 tx_eot high at end", {31'b0, tx_eot}, 1);
        tick(); tick();
    endtask

    task automatic t_prio();
        int base = log_n;
        stall_cfg = 0; stall_left = 0; ack_delay = 1;
        wr(2'd0, 32'h20); wr(2'd1, 32'd2);
        wr(2'd2, 32'h90); wr(2'd3, 32'd2);
        rx_q[0] = 8'h5C; rx_q[1] = 8'h5D; rx_i = 0;
        rx_n = 2; tx_en = 1;     // both become visible on the same edge
        wait_eot(1);
        wait_eot(0);
        tx_en = 0;
        chk("R8 four transactions", log_n - base, 4);
        chk("R8 first served is rx", {31'b0, log_we[base]}, 1);
        chk("R8 second served is rx", log_addr[base + 1], 32'h21);
        chk("R8 tx after rx", log_addr[base + 2], 32'h90);
        rx_n = 0; rx_i = 0;
        tick(); tick();
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        tx_n = 0; mem[8'hFF] = 8'h5A;
        wr(2'd2, 32'hFFFF_FFFF); wr(2'd3, 32'd1);
        tx_en = 1;
        wait_eot(1);
        tx_en = 0;
        rd(2'd2, d); chk("R10 pointer wraps to zero", d, 0);
        chk("R10 byte at top address", tx_got[0], 8'h5A);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_regs();
        t_zero();
        t_rx();
        t_tx();
        t_prio();
        t_wrap();
        chk("R7 request held and single outstanding", viol, 0);
        chk("R7 stall cycles exercised", {31'b0, held > 0}, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule